// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped controller for the two-wire management bus that reads and writes the registers of Ethernet PHYs. The host writes a PHY port address and a register number into an address register. Writing the write-data register sends a clause 22 write frame. A read frame starts when bit 0 of the command register changes from 0 to 1. The block drives the management clock and the data line, and gives the data line an output enable so that a pad can tri-state it.

The host watches an indicator register. Its busy flag covers every frame. Its not-valid flag covers a read from the moment the read starts until the returned word has been captured. When both flags read low, the word in the read-data register is current. A configuration register holds a soft reset bit, which stops any frame in progress and holds the logic idle. It also holds the clock divider that keeps the management clock within the PHY's rate limit.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The address register (select 2) takes the PHY port address from bits 12:8 and the register number from bits 4:0. The next frame carries both fields, port address first, each MSB first.
- R2: A write to select 3 while idle starts a 64-bit write frame. The frame is sent MSB first: 32 ones, then start bits 01, opcode 01, the 5-bit port address, the 5-bit register number, turnaround 10, and the low 16 bits of the written word. The output enable stays high for the whole frame.
- R3: A read frame starts only when a write to the command register (select 1) takes bit 0 from 0 to 1. Writing 1 while bit 0 already holds 1 starts no frame.
- R4: The indicator register (select 5) bit 0 reads 1 from the cycle after a frame starts until that frame ends.
- R5: Indicator bit 2 (not-valid) is set when a read starts and cleared when the read word is captured. Indicator bits 0 and 2 both low mark a finished read.
- R6: A read frame sends opcode 10 and drives the first turnaround bit high. It drops the output enable from frame bit 47 (counting from 0) to the end. It samples the 16 data bits on rising management-clock edges, MSB first, and presents them in bits 15:0 of select 4.
- R7: Bit 31 of the configuration register (select 0) is a soft reset. While it is set, any frame is aborted, busy and not-valid read 0, the clock and output enable are low, and no frame can start. After it is cleared, busy reads 0.
- R8: Configuration bits 7:0 set the divider. The management clock is high for max(div,1) system clocks and low for the same number, so the smallest division is 2. After reset the divider field reads 20.
- R9: An attempt to start a frame while busy is ignored. The address, write-data and command registers still take the written value, and a later frame uses it.
- R10: While no frame runs, the management clock and the output enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 3 | Register select for writes |
| bus_wdata | input | 32 | Register write data |
| bus_rsel | input | 3 | Register select for reads |
| bus_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input from the pad |

## Verification
The bench captures every management-clock bit of a write carrying one address and data pattern. This exposes field order, opcode and turnaround errors. Two reads with different addresses and different returned words (one dense, one with a single low bit set) separate correct sampling position and bit order from shifted or reversed capture, and they check that the output enable is released at the right bit. Repeated command writes at 1, start attempts during a busy frame and writes made under soft reset distinguish edge-triggered starts from level-triggered starts and show that blocked starts are really ignored. Half-period measurements at two divider values check the clock generator's minimum-divide rule.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int SEL_W       = 3;
    localparam int FRAME_BITS  = 64;
    localparam int BIT_W       = $clog2(FRAME_BITS);
    localparam int RD_RELEASE  = 47;
    localparam int RD_FIRST    = 48;

    typedef enum logic [SEL_W-1:0] {
        SEL_CFG   = 3'd0,
        SEL_CMD   = 3'd1,
        SEL_ADR   = 3'd2,
        SEL_WDATA = 3'd3,
        SEL_RDATA = 3'd4,
        SEL_IND   = 3'd5
    } sel_e;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic        is_rd,
        input logic [4:0]  phy,
        input logic [4:0]  regn,
        input logic [15:0] data
    );
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] pay;
        op  = is_rd ? 2'b10 : 2'b01;
        ta  = is_rd ? 2'b11 : 2'b10;
        pay = is_rd ? 16'hFFFF : data;
        return {32'hFFFF_FFFF, 2'b01, op, phy, regn, ta, pay};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t             q, d;
    logic [DIV_W-1:0] half;
    logic             wrap;
    logic             live;

    always_comb begin
        half     = (div == '0) ? DIV_W'(1) : div;
        wrap     = (q.cnt == half - 1'b1);
        live     = run && !clear;
        rise_stb = live && wrap && !q.mdc;
        fall_stb = live && wrap && q.mdc;
        d        = q;
        if (!live) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (wrap) begin
            d.cnt = '0;
            d.mdc = !q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc = q.mdc;

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        start,
    input  logic        start_rd,
    input  logic [4:0]  phy,
    input  logic [4:0]  regn,
    input  logic [15:0] wdata,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        rd_done,
    output logic [15:0] rd_val
);

    typedef struct packed {
        logic                  busy;
        logic                  rd;
        logic [BIT_W-1:0]      bitn;
        logic [FRAME_BITS-1:0] sh;
        logic [15:0]           rsh;
        logic                  done;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (clear) begin
            d.busy = 1'b0;
            d.rd   = 1'b0;
            d.bitn = '0;
        end else if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.rd   = start_rd;
                d.bitn = '0;
                d.sh   = build_frame(start_rd, phy, regn, wdata);
            end
        end else begin
            if (rise_stb && q.rd && (q.bitn >= BIT_W'(RD_FIRST))) begin
                d.rsh = {q.rsh[14:0], mdio_i};
            end
            if (fall_stb) begin
                if (q.bitn == BIT_W'(FRAME_BITS - 1)) begin
                    d.busy = 1'b0;
                    d.done = q.rd;
                end else begin
                    d.bitn = q.bitn + 1'b1;
                    d.sh   = {q.sh[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign mdio_o  = q.busy ? q.sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = q.busy && !(q.rd && (q.bitn >= BIT_W'(RD_RELEASE)));
    assign rd_done = q.done;
    assign rd_val  = q.rsh;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int INIT_DIV = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_sel,
    input  logic [31:0] bus_wdata,
    input  logic [2:0]  bus_rsel,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    typedef struct packed {
        logic             cfg_rst;
        logic [DIV_W-1:0] div;
        logic             cmd_rd;
        logic [4:0]       phy;
        logic [4:0]       regn;
        logic [15:0]      wdata;
        logic [15:0]      rdata;
        logic             notvalid;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        cfg_rst: 1'b0, div: DIV_W'(INIT_DIV), cmd_rd: 1'b0, phy: '0,
        regn: '0, wdata: '0, rdata: '0, notvalid: 1'b0
    };

    regs_t       q, d;
    logic        wr_cfg, wr_cmd, wr_adr, wr_wd;
    logic        go, go_rd;
    logic [15:0] eng_wdata;
    logic        eng_busy, rd_done;
    logic [15:0] rd_val;
    logic        rise_stb, fall_stb;
    logic        nv_q, cfg_rst_q;
    logic        unused_wbits;

    assign unused_wbits = ^bus_wdata[30:16];

    always_comb begin
        wr_cfg    = bus_wr && (bus_sel == SEL_CFG);
        wr_cmd    = bus_wr && (bus_sel == SEL_CMD);
        wr_adr    = bus_wr && (bus_sel == SEL_ADR);
        wr_wd     = bus_wr && (bus_sel == SEL_WDATA);
        go_rd     = wr_cmd && bus_wdata[0] && !q.cmd_rd && !eng_busy && !q.cfg_rst;
        go        = go_rd || (wr_wd && !eng_busy && !q.cfg_rst);
        eng_wdata = wr_wd ? bus_wdata[15:0] : q.wdata;

        d = q;
        if (wr_cfg) begin
            d.cfg_rst = bus_wdata[31];
            d.div     = bus_wdata[DIV_W-1:0];
        end
        if (wr_cmd) d.cmd_rd = bus_wdata[0];
        if (wr_adr) begin
            d.phy  = bus_wdata[12:8];
            d.regn = bus_wdata[4:0];
        end
        if (wr_wd) d.wdata = bus_wdata[15:0];
        if (go_rd) d.notvalid = 1'b1;
        if (rd_done) begin
            d.rdata    = rd_val;
            d.notvalid = 1'b0;
        end
        if (q.cfg_rst) d.notvalid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    always_comb begin
        case (bus_rsel)
            SEL_CFG:   bus_rdata = {q.cfg_rst, {(31-DIV_W){1'b0}}, q.div};
            SEL_CMD:   bus_rdata = {31'b0, q.cmd_rd};
            SEL_ADR:   bus_rdata = {19'b0, q.phy, 3'b0, q.regn};
            SEL_WDATA: bus_rdata = {16'b0, q.wdata};
            SEL_RDATA: bus_rdata = {16'b0, q.rdata};
            SEL_IND:   bus_rdata = {29'b0, q.notvalid, 1'b0, eng_busy};
            default:   bus_rdata = '0;
        endcase
    end

    assign nv_q      = q.notvalid;
    assign cfg_rst_q = q.cfg_rst;

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (q.cfg_rst),
        .run      (eng_busy),
        .div      (q.div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_eng u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (q.cfg_rst),
        .start    (go),
        .start_rd (go_rd),
        .phy      (q.phy),
        .regn     (q.regn),
        .wdata    (eng_wdata),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (eng_busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done),
        .rd_val   (rd_val)
    );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic notvalid,
    input logic cfg_rst,
    input logic mdc,
    input logic mdio_oe
);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    assert_soft_reset_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rst && $past(cfg_rst)) |-> (!busy && !notvalid));

    assert_notvalid_with_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(notvalid) |-> $rose(busy));

    assert_notvalid_after_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(notvalid) |-> !busy);

    assert_no_start_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !$rose(notvalid));

endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (eng_busy),
    .notvalid (nv_q),
    .cfg_rst  (cfg_rst_q),
    .mdc      (mdc),
    .mdio_oe  (mdio_oe)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic [31:0] bus_wdata = '0;
    logic [2:0]  bus_rsel = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [63:0] cap = '0;
    logic [63:0] oecap = '0;
    int          bitn = 0;
    int          base = 0;
    logic [15:0] phy_val = '0;

    always #(CLK_PERIOD/2) clk = !clk;

    mdio_mgmt_master u_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rsel(bus_rsel), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: record driven bits on rising clock, present read data after falling clock
    always @(posedge mdc) begin
        cap   <= {cap[62:0], mdio_o};
        oecap <= {oecap[62:0], mdio_oe};
        bitn  <= bitn + 1;
    end

    always @(negedge mdc) begin
        if ((bitn - base) >= 48 && (bitn - base) < 64) mdio_i <= phy_val[63 - (bitn - base)];
        else                                           mdio_i <= 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] sel, output logic [31:0] data);
        @(negedge clk);
        bus_rsel = sel;
        #1 data = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            bus_read(3'd5, v);
            if (v[2:0] == 3'b000) break;
        end
    endtask

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p, input logic [4:0] r, input logic [15:0] dt);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : dt)};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        bus_read(3'd5, v);
        check(v == 32'd0, "R4 reset indicator", 64'(v), 64'd0);
        check(!mdc && !mdio_oe, "R10 reset lines", {62'd0, mdc, mdio_oe}, 64'd0);
        bus_read(3'd0, v);
        check(v[7:0] == 8'd20, "R8 reset divider", 64'(v[7:0]), 64'd20);
    endtask

    task automatic t_divider(input logic [7:0] dv, input int exp_half);
        longint t1, t2;
        bus_write(3'd0, {24'd0, dv});
        bus_write(3'd3, 32'h0000_5555);
        @(posedge mdc); t1 = $time;
        @(negedge mdc); t2 = $time;
        check((t2 - t1) / CLK_PERIOD == exp_half, "R8 high half period", 64'((t2 - t1) / CLK_PERIOD), 64'(exp_half));
        t1 = t2;
        @(posedge mdc); t2 = $time;
        check((t2 - t1) / CLK_PERIOD == exp_half, "R8 low half period", 64'((t2 - t1) / CLK_PERIOD), 64'(exp_half));
        wait_idle();
    endtask

    task automatic t_write();
        logic [31:0] v;
        logic [63:0] e;
        bus_write(3'd2, 32'h0000_130A);
        base = bitn;
        bus_write(3'd3, 32'hFFFF_BEEF);
        bus_read(3'd5, v);
        check(v[0] == 1'b1, "R4 busy after write start", 64'(v[0]), 64'd1);
        wait_idle();
        e = exp_frame(1'b0, 5'h13, 5'h0A, 16'hBEEF);
        check(bitn - base == 64, "R2 write frame length", 64'(bitn - base), 64'd64);
        check(cap == e, "R1 R2 write frame bits", cap, e);
        check(oecap == '1, "R2 output enable during write", oecap, '1);
        check(!mdc && !mdio_oe, "R10 idle after write", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        base = bitn;
        bus_write(3'd3, 32'h0000_A5A5);
        repeat (20) @(negedge clk);
        bus_write(3'd3, 32'h0000_1234);
        bus_write(3'd1, 32'h0000_0001);
        wait_idle();
        check(bitn - base == 64, "R9 single frame despite busy writes", 64'(bitn - base), 64'd64);
        check(cap[15:0] == 16'hA5A5, "R9 first data kept", 64'(cap[15:0]), 64'hA5A5);
        bus_read(3'd3, v);
        check(v[15:0] == 16'h1234, "R9 write-data register updated", 64'(v[15:0]), 64'h1234);
        bus_read(3'd1, v);
        check(v[0] == 1'b1, "R9 command register updated", 64'(v[0]), 64'd1);
        // command bit already 1: writing 1 again must not start
        bus_write(3'd1, 32'h0000_0001);
        repeat (3) @(negedge clk);
        bus_read(3'd5, v);
        check(v[2:0] == 3'b000, "R3 no start without rising edge", 64'(v[2:0]), 64'd0);
    endtask

    task automatic t_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] pv);
        logic [31:0] v;
        logic [63:0] e;
        bus_write(3'd2, {19'd0, p, 3'd0, r});
        phy_val = pv;
        bus_write(3'd1, 32'h0);
        base = bitn;
        bus_write(3'd1, 32'h1);
        bus_read(3'd5, v);
        check(v[2:0] == 3'b101, "R3 R5 read started with not-valid", 64'(v[2:0]), 64'd5);
        repeat (100) @(negedge clk);
        bus_read(3'd5, v);
        check(v[2] == 1'b1, "R5 not-valid held mid-frame", 64'(v[2]), 64'd1);
        wait_idle();
        bus_read(3'd4, v);
        check(v[15:0] == pv, "R6 read data", 64'(v[15:0]), 64'(pv));
        e = exp_frame(1'b1, p, r, 16'h0);
        check(cap[63:17] == e[63:17], "R1 R6 read header bits", 64'(cap[63:17]), 64'(e[63:17]));
        check(oecap == {{47{1'b1}}, 17'd0}, "R6 output enable release", oecap, {{47{1'b1}}, 17'd0});
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        bus_write(3'd3, 32'h0000_F00F);
        repeat (60) @(negedge clk);
        bus_write(3'd0, 32'h8000_0002);
        repeat (3) @(negedge clk);
        bus_read(3'd5, v);
        check(v[0] == 1'b0, "R7 busy cleared by soft reset", 64'(v[0]), 64'd0);
        check(!mdc && !mdio_oe, "R7 lines low in soft reset", {62'd0, mdc, mdio_oe}, 64'd0);
        bus_write(3'd3, 32'h0000_0F0F);
        repeat (3) @(negedge clk);
        bus_read(3'd5, v);
        check(v[0] == 1'b0, "R7 no start while in soft reset", 64'(v[0]), 64'd0);
        bus_write(3'd0, 32'h0000_0002);
        repeat (2) @(negedge clk);
        bus_read(3'd5, v);
        check(v[2:0] == 3'b000, "R7 idle after release", 64'(v[2:0]), 64'd0);
        // abort a read: not-valid must also clear
        bus_write(3'd1, 32'h0);
        bus_write(3'd1, 32'h1);
        repeat (40) @(negedge clk);
        bus_write(3'd0, 32'h8000_0002);
        repeat (3) @(negedge clk);
        bus_read(3'd5, v);
        check(v[2:0] == 3'b000, "R7 read aborted clears flags", 64'(v[2:0]), 64'd0);
        bus_write(3'd0, 32'h0000_0002);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_divider(8'd3, 3);
        t_divider(8'd0, 1);
        bus_write(3'd0, 32'h0000_0002);
        t_write();
        t_busy_ignore();
        t_read(5'h1B, 5'h02, 16'hC3A5);
        t_read(5'h04, 5'h11, 16'h0001);
        t_soft_reset();
        t_read(5'h09, 5'h1F, 16'h8E71);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule